// File: doc/BRIEF.md
# Accumulator Register-Pair Transfer Unit

This block sits beside an integer pipeline. It holds one 40-bit accumulator and executes the two instructions that move data between that accumulator and a pair of 32-bit general registers. The pipeline presents a 32-bit instruction word together with a valid strobe, the result of the condition check it has already done, the two source register values, and the enable bit for coprocessor 0 access. The unit recognises its own opcode pattern, checks the encoding, and then does one of three things: it loads the accumulator, it returns the accumulator as two 32-bit values, or it reports an undefined encoding or a permission fault.

The accumulator does not divide evenly into the register pair. Its low 32 bits map to the low register. Its top 8 bits come from the lowest byte of the high register on a load. On a read they return to the high register as a sign-extended 32-bit value. The two register index fields are passed out with each read result so that the register file can write the values back.

Top module: `acc_xfer_unit`

## Requirements
- R1: The unit acts on an instruction word only when bits 27:21 equal binary 1100010. Any other pattern produces no result, no flag and no change to the accumulator.
- R2: Bit 20 selects the direction. A value of 0 loads the accumulator from the register pair, and a value of 1 reads the accumulator out to the register pair.
- R3: A permitted load sets accumulator bits 31:0 to `src_lo` and bits 39:32 to `src_hi[7:0]`. Bits 31:8 of `src_hi` are ignored. A read issued in the very next cycle returns the new value.
- R4: A permitted read drives `res_lo` = accumulator[31:0] and `res_hi` = accumulator[39:32] sign-extended from bit 39, on the cycle after the strobe. `res_valid` is high for exactly that one cycle. Loads never raise `res_valid`.
- R5: With each read result, `hi_idx` carries instruction bits 19:16 and `lo_idx` carries bits 15:12.
- R6: A nonzero accumulator selector in bits 2:0 is undefined. `undef_flag` pulses for one cycle after the strobe, and no transfer takes place.
- R7: Nonzero bits 11:3 are undefined. `undef_flag` pulses for one cycle after the strobe, and no transfer takes place.
- R8: A well-formed instruction with `cp_access_en` low pulses `perm_fault` for one cycle after the strobe and performs no transfer. An undefined encoding takes priority over the fault.
- R9: When `cond_pass` is low, the instruction has no effect at all: no result, no flag and no accumulator change.
- R10: While `rst_n` is low at a clock edge, the accumulator and all outputs clear to zero.
- R11: When `insn_valid` is low, the instruction word and data inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| insn_valid | input | 1 | Instruction word is presented this cycle |
| insn_word | input | 32 | Instruction word |
| cond_pass | input | 1 | Condition field evaluated true upstream |
| cp_access_en | input | 1 | Coprocessor 0 access enable (bit 0 of the access register) |
| src_hi | input | 32 | High source register value |
| src_lo | input | 32 | Low source register value |
| res_hi | output | 32 | Sign-extended accumulator bits 39:32 |
| res_lo | output | 32 | Accumulator bits 31:0 |
| res_valid | output | 1 | One-cycle read result strobe |
| hi_idx | output | 4 | Destination index for `res_hi` |
| lo_idx | output | 4 | Destination index for `res_lo` |
| undef_flag | output | 1 | One-cycle undefined-encoding pulse |
| perm_fault | output | 1 | One-cycle permission fault pulse |

## Verification
Each output is registered once. A read result, its index fields, an undefined pulse and a fault pulse therefore all appear exactly one edge after the strobed cycle. A load changes the accumulator at that same edge, so the effect of a load can be seen through a read issued in the next cycle. The bench model advances its own expected outputs on that same edge. It compares every output at the following falling edge, tagging each comparison with the requirement of the instruction that was issued one cycle before. Ignored and faulting instructions are always followed by a read, which shows at the ports that the accumulator was left alone.

// File: rtl/acc_xfer_pkg.sv
// Package acc_xfer_pkg
// Shared widths, field positions and the decoded-operation type for the
// accumulator transfer unit. Assumes a 32-bit instruction word.
package acc_xfer_pkg;
    localparam int REG_W      = 32;
    localparam int ACC_W      = 40;
    localparam int HI_W       = ACC_W - REG_W;
    localparam int IDX_W      = 4;
    localparam int SEL_W      = 3;
    localparam int OPC_W      = 7;
    localparam int OPC_LSB    = 21;
    localparam int DIR_BIT    = 20;
    localparam int HIDX_LSB   = 16;
    localparam int LIDX_LSB   = 12;
    localparam int SBZ_LSB    = 3;
    localparam int SBZ_W      = LIDX_LSB - SBZ_LSB;
    localparam logic [OPC_W-1:0] XFER_OPC = 7'b1100010;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_LOAD,
        OP_READ,
        OP_UNDEF,
        OP_DENY
    } xfer_op_e;
endpackage

// File: rtl/acc_xfer_decode.sv
// Module acc_xfer_decode
// Combinational decode of one instruction word into a single operation.
// Assumes the condition check and the access enable come from outside.
// Priority: not ours / condition failed -> undefined -> denied -> transfer.
module acc_xfer_decode
    import acc_xfer_pkg::*;
(
    input  logic              valid,
    input  logic [REG_W-1:0]  word,
    input  logic              cond_ok,
    input  logic              perm_ok,
    output xfer_op_e          op,
    output logic [IDX_W-1:0]  hi_idx,
    output logic [IDX_W-1:0]  lo_idx
);
    logic opc_hit;
    logic bad_enc;
    logic unused_cond;

    assign unused_cond = ^word[REG_W-1:OPC_LSB+OPC_W];
    assign opc_hit = word[OPC_LSB +: OPC_W] == XFER_OPC;
    assign bad_enc = (word[0 +: SEL_W] != '0) || (word[SBZ_LSB +: SBZ_W] != '0);
    assign hi_idx  = word[HIDX_LSB +: IDX_W];
    assign lo_idx  = word[LIDX_LSB +: IDX_W];

    // Select the operation by the fixed check priority.
    always_comb begin
        op = OP_NONE;
        if (valid && opc_hit && cond_ok) begin
            if (bad_enc)
                op = OP_UNDEF;
            else if (!perm_ok)
                op = OP_DENY;
            else if (word[DIR_BIT])
                op = OP_READ;
            else
                op = OP_LOAD;
        end
    end
endmodule

// File: rtl/acc_xfer_store.sv
// Module acc_xfer_store
// The accumulator register. It loads the full low word and only the low byte
// of the high word. Assumes load_en is already qualified by the decoder.
module acc_xfer_store
    import acc_xfer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [REG_W-1:0]  load_hi,
    input  logic [REG_W-1:0]  load_lo,
    output logic [ACC_W-1:0]  acc_q
);
    logic unused_hi_bits;
    assign unused_hi_bits = ^load_hi[REG_W-1:HI_W];

    // Hold the accumulator; update it on a qualified load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (load_en)
            acc_q <= {load_hi[HI_W-1:0], load_lo};
    end

    a_r3_load_low: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> acc_q[REG_W-1:0] == $past(load_lo));
    a_r3_load_top: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> acc_q[ACC_W-1:REG_W] == $past(load_hi[HI_W-1:0]));
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(acc_q));
endmodule

// File: rtl/acc_xfer_out.sv
// Module acc_xfer_out
// Registered result and flag stage. A read captures the accumulator and the
// index fields. The flags are one-cycle pulses. Assumes one operation per cycle.
module acc_xfer_out
    import acc_xfer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  xfer_op_e          op,
    input  logic [IDX_W-1:0]  hi_idx_in,
    input  logic [IDX_W-1:0]  lo_idx_in,
    input  logic [ACC_W-1:0]  acc_q,
    output logic [REG_W-1:0]  res_hi,
    output logic [REG_W-1:0]  res_lo,
    output logic              res_valid,
    output logic [IDX_W-1:0]  hi_idx,
    output logic [IDX_W-1:0]  lo_idx,
    output logic              undef_flag,
    output logic              perm_fault
);
    logic [REG_W-1:0] hi_ext;

    // Sign-extend the accumulator's top part to a full register.
    always_comb begin
        hi_ext = {{(REG_W-HI_W){acc_q[ACC_W-1]}}, acc_q[ACC_W-1:REG_W]};
    end

    // Register read data and index fields when a read is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_hi <= '0;
            res_lo <= '0;
            hi_idx <= '0;
            lo_idx <= '0;
        end else if (op == OP_READ) begin
            res_hi <= hi_ext;
            res_lo <= acc_q[REG_W-1:0];
            hi_idx <= hi_idx_in;
            lo_idx <= lo_idx_in;
        end
    end

    // Produce the one-cycle strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            undef_flag <= 1'b0;
            perm_fault <= 1'b0;
        end else begin
            res_valid  <= op == OP_READ;
            undef_flag <= op == OP_UNDEF;
            perm_fault <= op == OP_DENY;
        end
    end

    a_r4_low_word: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> res_lo == $past(acc_q[REG_W-1:0]));
    a_r4_sign: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> res_hi[REG_W-1] == $past(acc_q[ACC_W-1]));
    a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_valid, undef_flag, perm_fault}));
endmodule

// File: rtl/acc_xfer_unit.sv
// Module acc_xfer_unit
// Top of the accumulator transfer unit: decode, accumulator store, and the
// registered output stage. Assumes the condition check is done upstream.
module acc_xfer_unit
    import acc_xfer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_valid,
    input  logic [31:0]       insn_word,
    input  logic              cond_pass,
    input  logic              cp_access_en,
    input  logic [31:0]       src_hi,
    input  logic [31:0]       src_lo,
    output logic [31:0]       res_hi,
    output logic [31:0]       res_lo,
    output logic              res_valid,
    output logic [3:0]        hi_idx,
    output logic [3:0]        lo_idx,
    output logic              undef_flag,
    output logic              perm_fault
);
    xfer_op_e          op;
    logic [IDX_W-1:0]  dec_hi_idx;
    logic [IDX_W-1:0]  dec_lo_idx;
    logic [ACC_W-1:0]  acc_q;

    acc_xfer_decode u_decode (
        .valid   (insn_valid),
        .word    (insn_word),
        .cond_ok (cond_pass),
        .perm_ok (cp_access_en),
        .op      (op),
        .hi_idx  (dec_hi_idx),
        .lo_idx  (dec_lo_idx)
    );

    acc_xfer_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (op == OP_LOAD),
        .load_hi (src_hi),
        .load_lo (src_lo),
        .acc_q   (acc_q)
    );

    acc_xfer_out u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op),
        .hi_idx_in  (dec_hi_idx),
        .lo_idx_in  (dec_lo_idx),
        .acc_q      (acc_q),
        .res_hi     (res_hi),
        .res_lo     (res_lo),
        .res_valid  (res_valid),
        .hi_idx     (hi_idx),
        .lo_idx     (lo_idx),
        .undef_flag (undef_flag),
        .perm_fault (perm_fault)
    );

    a_r9_cond_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && !cond_pass) |=> !(res_valid || undef_flag || perm_fault));
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_valid |=> !(res_valid || undef_flag || perm_fault));
    a_r8_denied: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && cond_pass && !cp_access_en
         && insn_word[27:21] == 7'b1100010 && insn_word[11:0] == 12'h000)
        |=> perm_fault);
    a_r6_bad_select: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && cond_pass && insn_word[27:21] == 7'b1100010
         && insn_word[2:0] != 3'd0) |=> (undef_flag && !perm_fault));
    a_r5_index: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (hi_idx == $past(insn_word[19:16])
                       && lo_idx == $past(insn_word[15:12])));
endmodule

// File: tb/acc_xfer_unit_tb_top.sv
module acc_xfer_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [31:0] insn_word = '0;
    logic        cond_pass = 1'b0;
    logic        cp_access_en = 1'b0;
    logic [31:0] src_hi = '0;
    logic [31:0] src_lo = '0;
    logic [31:0] res_hi, res_lo;
    logic        res_valid, undef_flag, perm_fault;
    logic [3:0]  hi_idx, lo_idx;

    int    n_checks = 0;
    int    n_fails  = 0;
    int    cycles   = 0;
    string cur_tag  = "R10";
    string e_tag    = "R10";
    bit    checking = 1'b0;

    logic [39:0] m_acc;
    logic [31:0] e_hi, e_lo;
    logic        e_v, e_u, e_f;
    logic [3:0]  e_hidx, e_lidx;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_xfer_unit dut_i (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_word(insn_word),
        .cond_pass(cond_pass), .cp_access_en(cp_access_en), .src_hi(src_hi),
        .src_lo(src_lo), .res_hi(res_hi), .res_lo(res_lo), .res_valid(res_valid),
        .hi_idx(hi_idx), .lo_idx(lo_idx), .undef_flag(undef_flag),
        .perm_fault(perm_fault)
    );

    function automatic logic [31:0] mkw(bit rd, logic [3:0] hi, logic [3:0] lo,
                                        logic [8:0] sbz, logic [2:0] sel);
        return {4'hE, 7'b1100010, rd, hi, lo, sbz, sel};
    endfunction

    // Reference model: advance the expected outputs at every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc <= '0; e_hi <= '0; e_lo <= '0; e_v <= 0; e_u <= 0; e_f <= 0;
            e_hidx <= '0; e_lidx <= '0; e_tag <= "R10";
        end else begin
            e_v <= 0; e_u <= 0; e_f <= 0; e_tag <= cur_tag;
            if (insn_valid && cond_pass && insn_word[27:21] == 7'h62) begin
                if (insn_word[2:0] != 0 || insn_word[11:3] != 0) e_u <= 1;
                else if (!cp_access_en) e_f <= 1;
                else if (insn_word[20]) begin
                    logic [31:0] t;
                    t = {24'h0, m_acc[39:32]};
                    if (m_acc[39]) t = t | 32'hFFFF_FF00;
                    e_v <= 1; e_hi <= t; e_lo <= m_acc[31:0];
                    e_hidx <= insn_word[19:16]; e_lidx <= insn_word[15:12];
                end else
                    m_acc <= {src_hi[7:0], src_lo};
            end
        end
    end

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL [%s] %s actual=%h expected=%h", e_tag, what, act, exp);
        end
    endtask

    // Compare every output away from the active edge.
    always @(negedge clk) begin
        if (checking) begin
            chk("res_valid", 32'(res_valid), 32'(e_v));
            chk("undef_flag", 32'(undef_flag), 32'(e_u));
            chk("perm_fault", 32'(perm_fault), 32'(e_f));
            chk("res_hi", res_hi, e_hi);
            chk("res_lo", res_lo, e_lo);
            chk("hi_idx", 32'(hi_idx), 32'(e_hidx));
            chk("lo_idx", 32'(lo_idx), 32'(e_lidx));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_fails++;
            $display("FAIL [R1] watchdog actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    task automatic issue(string tag, logic [31:0] w, logic [31:0] hi, logic [31:0] lo,
                         bit v = 1, bit c = 1, bit p = 1);
        @(negedge clk);
        cur_tag = tag; insn_valid = v; insn_word = w; cond_pass = c;
        cp_access_en = p; src_hi = hi; src_lo = lo;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) issue(cur_tag, '0, '0, '0, 0, 0, 0);
    endtask

    initial begin
        @(negedge clk); checking = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: read right after reset returns zero
        issue("R10", mkw(1, 4'd1, 4'd2, 0, 0), '0, '0);
        // R3: load ignores high bits of src_hi; R4 read-after-load next cycle
        issue("R3", mkw(0, 4'd0, 4'd0, 0, 0), 32'hFFFF_FF5A, 32'h1234_5678);
        issue("R4", mkw(1, 4'd3, 4'd4, 0, 0), '0, '0);
        // R4: negative top byte sign-extends
        issue("R3", mkw(0, 4'd0, 4'd0, 0, 0), 32'h0000_0080, 32'hDEAD_BEEF);
        issue("R4", mkw(1, 4'd15, 4'd0, 0, 0), '0, '0);
        issue("R4", mkw(1, 4'd7, 4'd9, 0, 0), '0, '0);
        // R5: index fields
        issue("R5", mkw(1, 4'd10, 4'd5, 0, 0), '0, '0);
        // R6: bad selector, then read shows unchanged state
        issue("R6", mkw(0, 4'd0, 4'd0, 0, 3'd3), 32'h11, 32'h2222_2222);
        issue("R6", mkw(1, 4'd1, 4'd1, 0, 0), '0, '0);
        issue("R6", mkw(1, 4'd1, 4'd1, 0, 3'd7), '0, '0);
        // R7: nonzero should-be-zero bits
        issue("R7", mkw(0, 4'd0, 4'd0, 9'h100, 0), 32'h33, 32'h4444_4444);
        issue("R7", mkw(1, 4'd2, 4'd2, 0, 0), '0, '0);
        issue("R7", mkw(1, 4'd2, 4'd2, 9'h001, 0), '0, '0);
        // R8: permission fault; undefined wins over fault
        issue("R8", mkw(0, 4'd0, 4'd0, 0, 0), 32'h55, 32'h6666_6666, 1, 1, 0);
        issue("R8", mkw(1, 4'd3, 4'd3, 0, 0), '0, '0, 1, 1, 0);
        issue("R8", mkw(1, 4'd3, 4'd3, 0, 3'd1), '0, '0, 1, 1, 0);
        issue("R8", mkw(1, 4'd3, 4'd3, 0, 0), '0, '0);
        // R9: condition failed, even on a bad encoding
        issue("R9", mkw(0, 4'd0, 4'd0, 0, 0), 32'h77, 32'h8888_8888, 1, 0, 1);
        issue("R9", mkw(0, 4'd0, 4'd0, 9'h1FF, 3'd5), '0, '0, 1, 0, 0);
        issue("R9", mkw(1, 4'd6, 4'd6, 0, 0), '0, '0);
        // R1: other opcode pattern is ignored
        issue("R1", mkw(0, 4'd0, 4'd0, 0, 0) ^ 32'h0020_0000, 32'h99, 32'hAAAA_AAAA);
        issue("R1", mkw(1, 4'd8, 4'd8, 0, 0), '0, '0);
        // R11: strobe low ignores everything
        issue("R11", mkw(0, 4'd0, 4'd0, 0, 0), 32'hBB, 32'hCCCC_CCCC, 0);
        issue("R11", mkw(1, 4'd9, 4'd9, 0, 0), '0, '0);
        // R2: mixed traffic in both directions
        for (int i = 0; i < 400; i++) begin
            int k;
            logic [8:0] sbz;
            logic [2:0] sel;
            k = $urandom_range(0, 15);
            sbz = (k == 0) ? 9'($urandom_range(1, 511)) : 9'h0;
            sel = (k == 1) ? 3'($urandom_range(1, 7)) : 3'h0;
            issue("R2", mkw(1'($urandom_range(0, 1)), 4'($urandom), 4'($urandom), sbz, sel),
                  $urandom, $urandom, k != 2, k != 3, k != 4);
        end
        idle(3);
        // R10: reset mid-run clears state
        rst_n = 1'b0; cur_tag = "R10";
        idle(2);
        rst_n = 1'b1;
        issue("R10", mkw(1, 4'd1, 4'd1, 0, 0), '0, '0);
        idle(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule